// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Unit

This unit sits beside the command decoder and the write engine of a serial flash controller. It holds the write-enable latch and the three persistent protection bits: the hardware-protect enable, and a two-bit block-protect level. It produces the status byte that the status-read command shifts out. For every program or erase request it reports whether the target address may be written. It also accepts status-write requests and applies them through a short timed cycle.

A write is refused in four cases: the latch is clear, the address falls in a locked region, a write cycle is already running, or, for a status write, hardware protection is active. Hardware protection is active only while the protect-enable bit is set and the active-low protect pin is low. The persistent bits are plain registers with a reset value.

Top module: `wp_status_unit`

## Requirements
- R1: After reset the status byte reads 0x00, so the latch, the protect-enable bit and both block-protect bits are 0.
- R2: When no write cycle runs, the status byte has the protect-enable bit in bit 7, block-protect level bits [1:0] in bits 3:2, and the latch in bit 1. Bits 6:4 and bit 0 are 0.
- R3: The status byte reads 0xFF in every cycle where busy_i is high or the unit's own status-write cycle runs (sr_busy_o high).
- R4: wren_i sets the latch and wrdi_i clears it, with wrdi_i winning if both are high. Both are ignored while a write cycle runs. wr_done_i clears the latch in any state.
- R5: One cycle after arr_req_i, arr_valid_o pulses. arr_allow_o is 1 only if the latch is set, no cycle runs, and the address is not locked. The quarter index is the top two address bits. Level 00 locks nothing, 01 locks quarter 3, 10 locks quarters 2 and 3, and 11 locks all quarters. The protect pin and the protect-enable bit do not change this result.
- R6: One cycle after sr_wr_req_i, sr_valid_o pulses. sr_allow_o is 1 only if the latch is set, no cycle runs, and hardware protection (protect-enable 1 and wp_ni low) is inactive. With protect-enable 0, wp_ni has no effect.
- R7: If hardware protection is active in any cycle while sr_entry_i is high, a status-write request in that same entry is refused, even if wp_ni has returned high.
- R8: An accepted status write keeps sr_busy_o high for SR_CYC cycles. At the end it loads protect-enable from data bit 7 and the level from data bits 3:2, and clears the latch. Changes on wp_ni during the cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_ni | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Array program or erase cycle running |
| wren_i | input | 1 | Set-latch command pulse |
| wrdi_i | input | 1 | Clear-latch command pulse |
| wr_done_i | input | 1 | Array write cycle finished |
| arr_req_i | input | 1 | Array write permission request |
| arr_addr_i | input | ADDR_W | Array target address |
| arr_valid_o | output | 1 | Array decision valid |
| arr_allow_o | output | 1 | Array write allowed |
| sr_entry_i | input | 1 | Status-write command entry in progress |
| sr_wr_req_i | input | 1 | Status-write request at end of entry |
| sr_wr_data_i | input | 8 | Status-write data byte |
| sr_valid_o | output | 1 | Status-write decision valid |
| sr_allow_o | output | 1 | Status write accepted |
| sr_busy_o | output | 1 | Status-write cycle running |
| status_o | output | 8 | Status byte |

## Verification
The protect pin can fall during a status-write entry and rise again before the request arrives. In that case the cancel memory and the instantaneous protection check disagree, and the request must still be refused. The bench drives the pin low and back high within one entry, then compares the result with a clean entry right after it. The second collision is a pin change during a running status-write cycle. The bench judges it by the status byte read once the cycle ends.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int SR_WPEN = 7;
  localparam int SR_BP1  = 3;
  localparam int SR_BP0  = 2;
  localparam int SR_WEN  = 1;
  localparam int SR_RDY  = 0;
  localparam logic [7:0] SR_BUSY_BYTE = 8'hFF;
endpackage

// File: rtl/wp_lock_map.sv
module wp_lock_map #(
  parameter int ADDR_W = 18
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        level_i,
  output logic              locked_o
);
  logic [1:0] quarter;
  assign quarter = addr_i[ADDR_W-1 -: 2];

  always_comb begin
    unique case (level_i)
      2'b00:   locked_o = 1'b0;
      2'b01:   locked_o = (quarter == 2'b11);
      2'b10:   locked_o = quarter[1];
      default: locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wp_sr_timer.sv
module wp_sr_timer #(
  parameter int SR_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(SR_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CNT_W'(SR_CYC);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/wp_status_unit.sv
module wp_status_unit #(
  parameter int ADDR_W = 18,
  parameter int SR_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_ni,
  input  logic              busy_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wr_done_i,
  input  logic              arr_req_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  output logic              arr_valid_o,
  output logic              arr_allow_o,
  input  logic              sr_entry_i,
  input  logic              sr_wr_req_i,
  input  logic [7:0]        sr_wr_data_i,
  output logic              sr_valid_o,
  output logic              sr_allow_o,
  output logic              sr_busy_o,
  output logic [7:0]        status_o
);
  import wp_pkg::*;

  logic       wen_q, wpen_q, cancel_q;
  logic [1:0] bp_q, bp_pend_q;
  logic       wpen_pend_q;
  logic       any_busy, hw_prot, locked, sr_ok, arr_ok, sr_done;

  wp_lock_map #(.ADDR_W(ADDR_W)) u_lock (
    .addr_i  (arr_addr_i),
    .level_i (bp_q),
    .locked_o(locked)
  );

  wp_sr_timer #(.SR_CYC(SR_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(sr_ok),
    .busy_o (sr_busy_o),
    .done_o (sr_done)
  );

  assign any_busy = busy_i | sr_busy_o;
  assign hw_prot  = wpen_q & ~wp_ni;
  assign sr_ok    = sr_wr_req_i & wen_q & ~any_busy & ~hw_prot & ~cancel_q;
  assign arr_ok   = wen_q & ~any_busy & ~locked;

  // remembers a protect-pin hit anywhere inside the current status-write entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cancel_q <= 1'b0;
    else if (!sr_entry_i) cancel_q <= 1'b0;
    else if (hw_prot)     cancel_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q <= 1'b0;
    end else if (sr_done || wr_done_i) begin
      wen_q <= 1'b0;
    end else if (!any_busy) begin
      if (wrdi_i)      wen_q <= 1'b0;
      else if (wren_i) wen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wpen_q      <= 1'b0;
      bp_q        <= 2'b00;
      wpen_pend_q <= 1'b0;
      bp_pend_q   <= 2'b00;
    end else begin
      if (sr_ok) begin
        wpen_pend_q <= sr_wr_data_i[SR_WPEN];
        bp_pend_q   <= sr_wr_data_i[SR_BP1:SR_BP0];
      end
      if (sr_done) begin
        wpen_q <= wpen_pend_q;
        bp_q   <= bp_pend_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arr_valid_o <= 1'b0;
      arr_allow_o <= 1'b0;
      sr_valid_o  <= 1'b0;
      sr_allow_o  <= 1'b0;
    end else begin
      arr_valid_o <= arr_req_i;
      arr_allow_o <= arr_req_i & arr_ok;
      sr_valid_o  <= sr_wr_req_i;
      sr_allow_o  <= sr_ok;
    end
  end

  always_comb begin
    if (any_busy) begin
      status_o = SR_BUSY_BYTE;
    end else begin
      status_o                  = '0;
      status_o[SR_WPEN]         = wpen_q;
      status_o[SR_BP1:SR_BP0]   = bp_q;
      status_o[SR_WEN]          = wen_q;
    end
  end
endmodule

// File: rtl/wp_status_chk.sv
module wp_status_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wp_ni,
  input logic       busy_i,
  input logic       arr_req_i,
  input logic       arr_valid_o,
  input logic       arr_allow_o,
  input logic       sr_allow_o,
  input logic       sr_busy_o,
  input logic [7:0] status_o,
  input logic       wen_q,
  input logic       wpen_q,
  input logic [1:0] bp_q
);
  assert_busy_ff_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i || sr_busy_o) |-> status_o == 8'hFF);

  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !sr_busy_o) |-> (status_o[6:4] == 3'b000 && !status_o[0]));

  assert_arr_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_valid_o |-> $past(arr_req_i));

  assert_arr_wen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_allow_o |-> ($past(wen_q) && $past(bp_q) != 2'b11 && arr_valid_o));

  assert_sr_prot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_allow_o |-> ($past(wen_q) && !($past(wpen_q) && !$past(wp_ni))));

  assert_sr_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_allow_o |-> sr_busy_o);

  assert_wen_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sr_busy_o) |-> !wen_q);
endmodule

bind wp_status_unit wp_status_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wp_ni      (wp_ni),
  .busy_i     (busy_i),
  .arr_req_i  (arr_req_i),
  .arr_valid_o(arr_valid_o),
  .arr_allow_o(arr_allow_o),
  .sr_allow_o (sr_allow_o),
  .sr_busy_o  (sr_busy_o),
  .status_o   (status_o),
  .wen_q      (wen_q),
  .wpen_q     (wpen_q),
  .bp_q       (bp_q)
);

// File: tb/wp_status_unit_tb.sv
module wp_status_unit_tb;
  localparam int ADDR_W = 18;
  localparam int SR_CYC = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wp_ni = 1'b1, busy_i = 1'b0, wren_i = 1'b0, wrdi_i = 1'b0, wr_done_i = 1'b0;
  logic arr_req_i = 1'b0;
  logic [ADDR_W-1:0] arr_addr_i = '0;
  logic arr_valid_o, arr_allow_o;
  logic sr_entry_i = 1'b0, sr_wr_req_i = 1'b0;
  logic [7:0] sr_wr_data_i = '0;
  logic sr_valid_o, sr_allow_o, sr_busy_o;
  logic [7:0] status_o;

  int n_chk = 0, n_fail = 0;
  logic       e_wen = 1'b0, e_wpen = 1'b0;
  logic [1:0] e_bp = 2'b00;

  always #10 clk_i = ~clk_i;

  wp_status_unit #(.ADDR_W(ADDR_W), .SR_CYC(SR_CYC)) u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status();
    return {e_wpen, 3'b000, e_bp, e_wen, 1'b0};
  endfunction

  task automatic cmd_wren();
    @(negedge clk_i); wren_i = 1'b1; @(negedge clk_i); wren_i = 1'b0;
    if (!busy_i && !sr_busy_o) e_wen = 1'b1;
  endtask

  task automatic cmd_wrdi();
    @(negedge clk_i); wrdi_i = 1'b1; @(negedge clk_i); wrdi_i = 1'b0;
    if (!busy_i && !sr_busy_o) e_wen = 1'b0;
  endtask

  // full status write; expected accept from R6/R7 model
  task automatic do_wrsr(input logic [7:0] d, input logic exp_ok, input string req);
    @(negedge clk_i); sr_entry_i = 1'b1; sr_wr_data_i = d;
    @(negedge clk_i); sr_wr_req_i = 1'b1;
    @(negedge clk_i); sr_wr_req_i = 1'b0; sr_entry_i = 1'b0;
    chk(req, {6'b0, sr_valid_o, sr_allow_o}, {6'b0, 1'b1, exp_ok});
    if (exp_ok) begin
      chk("R3 busy during status write", status_o, 8'hFF);
      repeat (SR_CYC) @(negedge clk_i);
      e_wpen = d[7]; e_bp = d[3:2]; e_wen = 1'b0;
    end
    chk("R8 status after write", status_o, exp_status());
  endtask

  task automatic arr_ask(input logic [ADDR_W-1:0] a, input logic exp_ok, input string req);
    @(negedge clk_i); arr_req_i = 1'b1; arr_addr_i = a;
    @(negedge clk_i); arr_req_i = 1'b0;
    chk(req, {6'b0, arr_valid_o, arr_allow_o}, {6'b0, 1'b1, exp_ok});
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset status", status_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 status after release", status_o, 8'h00);

    // R4: latch set/clear
    cmd_wren();  chk("R4 wren sets latch", status_o, exp_status());
    cmd_wrdi();  chk("R4 wrdi clears latch", status_o, 8'h00);
    @(negedge clk_i); wren_i = 1'b1; wrdi_i = 1'b1; @(negedge clk_i); wren_i = 1'b0; wrdi_i = 1'b0;
    chk("R4 wrdi wins over wren", status_o, 8'h00);

    // R5: sweep every level x quarter x latch, WP/WPEN irrelevant
    for (int lv = 0; lv < 4; lv++) begin
      wp_ni = 1'b1;
      cmd_wren();
      do_wrsr({1'b0, 3'b000, 2'(lv), 2'b00}, 1'b1, "R8 set level");
      chk("R2 layout idle", status_o, {4'b0000, 2'(lv), 2'b00});
      for (int w = 0; w < 2; w++) begin
        if (w == 1) cmd_wren(); else cmd_wrdi();
        wp_ni = w[0] ? 1'b0 : 1'b1;
        for (int q = 0; q < 4; q++) begin
          logic lk;
          lk = (lv == 3) || (lv == 2 && q >= 2) || (lv == 1 && q == 3);
          arr_ask({2'(q), 16'h5A5A}, (w == 1) && !lk, "R5 lock sweep");
        end
      end
    end
    wp_ni = 1'b1;
    cmd_wren();
    do_wrsr(8'h00, 1'b1, "R8 clear level");

    // R6: sweep protect-enable x pin x latch
    for (int pe = 0; pe < 2; pe++) begin
      for (int p = 0; p < 2; p++) begin
        for (int w = 0; w < 2; w++) begin
          wp_ni = 1'b1;
          cmd_wren();
          do_wrsr({1'(pe), 7'b0}, 1'b1, "R6 setup protect-enable");
          if (w == 1) cmd_wren(); else cmd_wrdi();
          wp_ni = 1'(p);
          do_wrsr({1'(pe), 7'b0}, (w == 1) && !(pe == 1 && p == 0), "R6 protect sweep");
        end
      end
    end

    // R7: pin pulse inside entry cancels, clean entry succeeds
    wp_ni = 1'b1;
    cmd_wren();
    do_wrsr(8'h80, 1'b1, "R7 setup");
    cmd_wren();
    @(negedge clk_i); sr_entry_i = 1'b1; sr_wr_data_i = 8'h8C;
    @(negedge clk_i); wp_ni = 1'b0;
    @(negedge clk_i); wp_ni = 1'b1;
    @(negedge clk_i); sr_wr_req_i = 1'b1;
    @(negedge clk_i); sr_wr_req_i = 1'b0; sr_entry_i = 1'b0;
    chk("R7 cancelled by pin pulse", {7'b0, sr_allow_o}, 8'h00);
    chk("R7 bits unchanged", status_o, exp_status());
    do_wrsr(8'h84, 1'b1, "R7 clean entry accepted");

    // R8: pin low during running cycle has no effect
    cmd_wren();
    @(negedge clk_i); sr_entry_i = 1'b1; sr_wr_data_i = 8'h88;
    @(negedge clk_i); sr_wr_req_i = 1'b1;
    @(negedge clk_i); sr_wr_req_i = 1'b0; sr_entry_i = 1'b0; wp_ni = 1'b0;
    chk("R8 accepted", {7'b0, sr_allow_o}, 8'h01);
    repeat (SR_CYC) @(negedge clk_i);
    chk("R8 written despite pin", status_o, 8'h88);
    wp_ni = 1'b1;

    // R3/R4/R5: external busy
    cmd_wren();
    busy_i = 1'b1;
    @(negedge clk_i);
    chk("R3 busy_i forces FF", status_o, 8'hFF);
    arr_ask(18'h00010, 1'b0, "R5 refused while busy");
    @(negedge clk_i); wrdi_i = 1'b1; @(negedge clk_i); wrdi_i = 1'b0;
    busy_i = 1'b0;
    @(negedge clk_i);
    chk("R4 wrdi ignored while busy", status_o, 8'h8A);
    @(negedge clk_i); wr_done_i = 1'b1; @(negedge clk_i); wr_done_i = 1'b0;
    e_wen = 1'b0;
    chk("R4 wr_done clears latch", status_o, 8'h88);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule